// File: doc/BRIEF.md
# Edge-Triggered Interrupt Aggregator with Write-Message Dispatch

This block gathers eleven level-sensitive interrupt lines into a single controller. It samples each line every clock, keeps a copy of the sampled levels, and records every low-to-high change as a sticky pending bit. A rising source that is enabled in the mask register is put in a dispatch queue. The dispatcher then produces one 32-bit write message toward the processor for each queued source.

Each message is built from one of two destination registers. A per-source class bit selects the destination: 1 selects destination B and 0 selects destination A. The message address is the destination register with its five low bits cleared. The message data is those five low bits. Placing the word on the system bus is left to the surrounding logic. The block presents a request with address and data and holds them until an acknowledge arrives.

Software reaches all state through a small register port. The port has a combinational read path, a clear-on-access pending register and two masked request views.

Source bit order: 0 to 5 are PCI lines A to F, 6 is the external line, 7 is bus error, 8 is PS/2, 9 is unused and 10 is the serial port.

Top module: `irq_msg_aggregator`

## Requirements
- R1: The level register holds the value of `irq_in` sampled at the previous clock edge. A bit is 1 while its input is high and returns to 0 after the input falls.
- R2: A pending bit is set only when its source goes from 0 to 1 in the level register. A source that stays high does not set a cleared pending bit again.
- R3: Reading the pending register (select 5) returns its current value and then clears it. Writing the pending register clears it whatever the write data is. A rise in the same cycle as the clear still leaves its bit set.
- R4: A rising source whose mask bit is 1 produces exactly one message. A rising source whose mask bit is 0 produces none. The class bit of the source selects destination B when it is 1 and destination A when it is 0.
- R5: A message carries address = destination with bits 4:0 cleared and data = destination bits 4:0, zero-extended to 32 bits. The request, address and data stay unchanged until `msg_ack` is seen high.
- R6: When several enabled sources rise together, their messages are issued one at a time in ascending bit order. At most one request is outstanding at any time.
- R7: Request view A (select 6) reads level & mask & ~class. Request view B (select 7) reads level & mask & class. Writes to the level register (select 4) and to either request view change nothing.
- R8: After reset, both destinations read 0xFFFB0003, the mask, class, level and pending registers read 0, and no request is raised.
- R9: Register select encoding: 0 is destination A, 1 is destination B, 2 is mask, 3 is class, 4 is level, 5 is pending, 6 is request view A and 7 is request view B. Bit i of every per-source register belongs to `irq_in[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 11 | Interrupt source levels |
| reg_sel | input | 3 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears pending when select is 5) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_sel` |
| msg_req | output | 1 | Message request |
| msg_addr | output | 32 | Message target address, 32-byte aligned |
| msg_data | output | 32 | Message data word |
| msg_ack | input | 1 | Message accepted |

## Verification
The assertions check the properties that hold on every cycle:
- the level register follows the sampled inputs;
- pending bits appear only on rises and always appear on a rise;
- a clear with no rise in the same cycle empties the pending register;
- a request holds its address and data until acknowledged;
- message addresses are aligned and message data stays below 32;
- at most one source is taken per cycle.

Only the bench scenarios can show the rest, because it depends on programmed values and on sequences of events:
- each source is routed to the right destination for both class values;
- a masked or already-high source stays silent;
- simultaneous rises are issued in ascending order;
- the read-only registers ignore writes.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned MSG_LOW_W = 5;
    localparam logic [WORD_W-1:0] DEST_RESET = 32'hFFFB_0003;

    typedef enum logic [2:0] {
        SEL_DEST_A = 3'd0,
        SEL_DEST_B = 3'd1,
        SEL_MASK   = 3'd2,
        SEL_CLASS  = 3'd3,
        SEL_LEVEL  = 3'd4,
        SEL_PEND   = 3'd5,
        SEL_REQ_A  = 3'd6,
        SEL_REQ_B  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } msg_t;

    // Split a destination register into an aligned target and a small payload.
    function automatic msg_t build_msg(input logic [WORD_W-1:0] dest);
        msg_t m;
        m.addr = {dest[WORD_W-1:MSG_LOW_W], {MSG_LOW_W{1'b0}}};
        m.data = {{(WORD_W-MSG_LOW_W){1'b0}}, dest[MSG_LOW_W-1:0]};
        return m;
    endfunction

endpackage

// File: rtl/irq_edge_track.sv
module irq_edge_track #(
    parameter int unsigned N_SRC = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_in,
    input  logic             pend_clr,
    output logic [N_SRC-1:0] lvl_o,
    output logic [N_SRC-1:0] rise_o,
    output logic [N_SRC-1:0] pend_o
);
    logic [N_SRC-1:0] lvl_q;
    logic [N_SRC-1:0] pend_q;

    assign rise_o = irq_in & ~lvl_q;
    assign lvl_o  = lvl_q;
    assign pend_o = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            pend_q <= '0;
        end else begin
            lvl_q  <= irq_in;
            pend_q <= (pend_clr ? '0 : pend_q) | rise_o;
        end
    end

    a_r1_level_tracks: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> lvl_q == $past(irq_in));

    a_r2_pend_on_rise: assert property (@(posedge clk) disable iff (rst)
        (|rise_o) |=> ((pend_q & $past(rise_o)) == $past(rise_o)));

    a_r2_pend_only_rise: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise_o)) == '0));

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_SRC = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        reg_sel,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic [N_SRC-1:0]  lvl,
    input  logic [N_SRC-1:0]  pend,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [N_SRC-1:0]  mask_o,
    output logic [N_SRC-1:0]  class_o,
    output logic [WORD_W-1:0] dest_a_o,
    output logic [WORD_W-1:0] dest_b_o,
    output logic              pend_clr_o
);
    localparam int unsigned PAD_W = WORD_W - N_SRC;

    logic [N_SRC-1:0]  mask_q, class_q;
    logic [WORD_W-1:0] dest_a_q, dest_b_q;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(reg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            class_q  <= '0;
            dest_a_q <= DEST_RESET;
            dest_b_q <= DEST_RESET;
        end else if (reg_we) begin
            case (sel)
                SEL_DEST_A: dest_a_q <= reg_wdata;
                SEL_DEST_B: dest_b_q <= reg_wdata;
                SEL_MASK:   mask_q   <= reg_wdata[N_SRC-1:0];
                SEL_CLASS:  class_q  <= reg_wdata[N_SRC-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_DEST_A: reg_rdata = dest_a_q;
            SEL_DEST_B: reg_rdata = dest_b_q;
            SEL_MASK:   reg_rdata = {{PAD_W{1'b0}}, mask_q};
            SEL_CLASS:  reg_rdata = {{PAD_W{1'b0}}, class_q};
            SEL_LEVEL:  reg_rdata = {{PAD_W{1'b0}}, lvl};
            SEL_PEND:   reg_rdata = {{PAD_W{1'b0}}, pend};
            SEL_REQ_A:  reg_rdata = {{PAD_W{1'b0}}, lvl & mask_q & ~class_q};
            default:    reg_rdata = {{PAD_W{1'b0}}, lvl & mask_q & class_q};
        endcase
    end

    assign pend_clr_o = (reg_we || reg_re) && (sel == SEL_PEND);
    assign mask_o     = mask_q;
    assign class_o    = class_q;
    assign dest_a_o   = dest_a_q;
    assign dest_b_o   = dest_b_q;

    a_r7_ro_mask_kept: assert property (@(posedge clk) disable iff (rst)
        (reg_we && sel != SEL_MASK) |=> $stable(mask_q));

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_SRC = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  fire,
    input  logic [N_SRC-1:0]  class_sel,
    input  logic [WORD_W-1:0] dest_a,
    input  logic [WORD_W-1:0] dest_b,
    input  logic              msg_ack,
    output logic              msg_req,
    output logic [WORD_W-1:0] msg_addr,
    output logic [WORD_W-1:0] msg_data
);
    logic [N_SRC-1:0] queue_q;
    logic [N_SRC-1:0] pick_oh;
    logic [N_SRC-1:0] take;
    logic             busy_q;
    logic             use_b;
    msg_t             msg_q;

    // Lowest set bit wins: scan downward so the last hit is the smallest index.
    always_comb begin
        pick_oh = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (queue_q[i]) pick_oh = {{(N_SRC-1){1'b0}}, 1'b1} << i;
        end
    end

    assign take  = busy_q ? '0 : pick_oh;
    assign use_b = |(pick_oh & class_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            queue_q <= '0;
            busy_q  <= 1'b0;
            msg_q   <= '0;
        end else begin
            queue_q <= (queue_q & ~take) | fire;
            if (busy_q) begin
                if (msg_ack) busy_q <= 1'b0;
            end else if (|queue_q) begin
                busy_q <= 1'b1;
                msg_q  <= build_msg(use_b ? dest_b : dest_a);
            end
        end
    end

    assign msg_req  = busy_q;
    assign msg_addr = msg_q.addr;
    assign msg_data = msg_q.data;

    a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (msg_req && !msg_ack) |=> (msg_req && $stable(msg_addr) && $stable(msg_data)));

    a_r5_addr_aligned: assert property (@(posedge clk) disable iff (rst)
        msg_req |-> (msg_addr[MSG_LOW_W-1:0] == '0));

    a_r5_data_small: assert property (@(posedge clk) disable iff (rst)
        msg_req |-> (msg_data < 32'd32));

    a_r6_single_take: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take));

endmodule

// File: rtl/irq_msg_aggregator.sv
module irq_msg_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_SRC = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic [2:0]        reg_sel,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              msg_req,
    output logic [WORD_W-1:0] msg_addr,
    output logic [WORD_W-1:0] msg_data,
    input  logic              msg_ack
);
    logic [N_SRC-1:0]  lvl, rise, pend, mask, cls;
    logic [WORD_W-1:0] dest_a, dest_b;
    logic              pend_clr;

    irq_edge_track #(.N_SRC(N_SRC)) u_edge (
        .clk(clk), .rst(rst), .irq_in(irq_in), .pend_clr(pend_clr),
        .lvl_o(lvl), .rise_o(rise), .pend_o(pend)
    );

    irq_regfile #(.N_SRC(N_SRC)) u_regs (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_re(reg_re), .reg_wdata(reg_wdata), .lvl(lvl), .pend(pend),
        .reg_rdata(reg_rdata), .mask_o(mask), .class_o(cls),
        .dest_a_o(dest_a), .dest_b_o(dest_b), .pend_clr_o(pend_clr)
    );

    irq_dispatch #(.N_SRC(N_SRC)) u_disp (
        .clk(clk), .rst(rst), .fire(rise & mask), .class_sel(cls),
        .dest_a(dest_a), .dest_b(dest_b), .msg_ack(msg_ack),
        .msg_req(msg_req), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    a_r3_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (pend_clr && rise == '0) |=> pend == '0);

endmodule

// File: tb/tb_irq_msg_aggregator.sv
module tb_irq_msg_aggregator;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned N = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] irq_in = '0;
    logic [2:0]  reg_sel = '0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_req;
    logic [31:0] msg_addr, msg_data;
    logic        msg_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_msg_aggregator dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_sel(reg_sel),
        .reg_we(reg_we), .reg_re(reg_re), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .msg_req(msg_req), .msg_addr(msg_addr),
        .msg_data(msg_data), .msg_ack(msg_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_re = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] sel, input logic [31:0] exp);
        logic [31:0] v;
        rd(sel, v);
        chk(tag, v, exp);
    endtask

    // Wait for a request, compare it, then acknowledge it for one cycle.
    task automatic take_msg(input string tag, input logic [31:0] dest);
        int n = 0;
        while (!msg_req && n < 20) begin @(negedge clk); n++; end
        chk({tag, " req"}, {31'b0, msg_req}, 32'd1);
        chk({tag, " addr"}, msg_addr, dest & 32'hFFFF_FFE0);
        chk({tag, " data"}, msg_data, dest & 32'h1F);
        msg_ack = 1'b1;
        @(negedge clk);
        msg_ack = 1'b0;
    endtask

    task automatic idle(input int cyc);
        for (int i = 0; i < cyc; i++) @(negedge clk);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
        end
    end

    initial begin
        logic [31:0] da, db, dsel;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk("R8 req", {31'b0, msg_req}, 32'd0);
        rd_chk("R8 destA", 3'd0, 32'hFFFB_0003);
        rd_chk("R8 destB", 3'd1, 32'hFFFB_0003);
        for (int s = 2; s < 8; s++) rd_chk("R8 zero regs", 3'(s), 32'd0);

        // R4 R5 R7 R9: each source, both classes
        for (int s = 0; s < N; s++) begin
            for (int c = 0; c < 2; c++) begin
                da = 32'hA000_0000 + (s << 8) + s;
                db = 32'hB000_0000 + (s << 8) + s + 16;
                wr(3'd0, da);
                wr(3'd1, db);
                wr(3'd2, 32'd1 << s);
                wr(3'd3, 32'(c) << s);
                irq_in = 11'(1 << s);
                dsel = c ? db : da;
                take_msg("R4 R5 dispatch", dsel);
                idle(4);
                chk("R6 single msg", {31'b0, msg_req}, 32'd0);
                rd_chk("R1 level high", 3'd4, 32'd1 << s);
                rd_chk("R7 reqA", 3'd6, c ? 32'd0 : (32'd1 << s));
                rd_chk("R7 reqB", 3'd7, c ? (32'd1 << s) : 32'd0);
                rd_chk("R3 pend read", 3'd5, 32'd1 << s);
                rd_chk("R3 pend cleared", 3'd5, 32'd0);
                @(negedge clk) irq_in = '0;
                idle(1);
                rd_chk("R1 level low", 3'd4, 32'd0);
            end
        end

        // R4 masked source: no message, pending still set
        wr(3'd2, 32'd0);
        irq_in = 11'h010;
        idle(6);
        chk("R4 masked no req", {31'b0, msg_req}, 32'd0);
        rd_chk("R2 masked pend", 3'd5, 32'h010);
        // R2 held-high source does not re-pend
        idle(4);
        rd_chk("R2 held no re-pend", 3'd5, 32'd0);
        // R3 write clears regardless of data
        irq_in = 11'h030;
        idle(2);
        wr(3'd5, 32'h0);
        rd_chk("R3 write clear", 3'd5, 32'd0);
        // R7 writes to read-only views ignored
        wr(3'd4, 32'h7FF);
        wr(3'd6, 32'h7FF);
        wr(3'd7, 32'h7FF);
        rd_chk("R7 level ro", 3'd4, 32'h030);
        wr(3'd2, 32'h7FF);
        wr(3'd3, 32'h010);
        rd_chk("R7 reqA view", 3'd6, 32'h020);
        rd_chk("R7 reqB view", 3'd7, 32'h010);
        @(negedge clk) irq_in = '0;
        idle(2);

        // R6 simultaneous rises: ascending order
        da = 32'hC000_0045;
        db = 32'hD000_1F3E;
        wr(3'd0, da);
        wr(3'd1, db);
        wr(3'd2, 32'h7FF);
        wr(3'd3, 32'h008);
        rd_chk("R3 pend empty", 3'd5, 32'd0);
        @(negedge clk) irq_in = 11'h08A;
        take_msg("R6 first bit1", da);
        chk("R6 one outstanding", {31'b0, msg_req}, 32'd0);
        take_msg("R6 second bit3", db);
        take_msg("R6 third bit7", da);
        idle(4);
        chk("R6 drained", {31'b0, msg_req}, 32'd0);
        rd_chk("R2 multi pend", 3'd5, 32'h08A);

        done = 1;
        report();
    end
endmodule